// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a stuck target holds hung. Software raises a single-cycle recover request; the sequencer looks at the sampled SDA and SCL levels and picks one of three paths. If both lines are already high, nothing is wrong, and the request completes at once. If SDA is held low, the sequencer clocks SCL one pulse at a time. After each high phase it checks whether SDA has been let go. It gives up after a fixed number of pulses. If SDA is high but SCL is low, it skips the pulses and only tries to close the bus with a STOP.

Each path ends with a one-cycle `done` strobe. The `fail` output is valid in that same cycle. Every SCL and SDA phase lasts from one `tick` of the shared timing generator to the next. Both drive outputs are open-drain style: a 1 pulls the wire low and a 0 releases it. Once `done` appears, software reads the live SDA level to decide whether the bus is usable.

Top module: `i2c_bus_unjam`

## Requirements
- R1: After reset, both drive outputs are 0 (released) and `done` and `fail` are 0.
- R2: A request made while `sda_in` and `scl_in` are both 1 raises `done` in the clock cycle right after the request is sampled, with `fail` 0 and no SCL pulse.
- R3: A request made while `sda_in` is 0 starts a pulse train. In each pulse, `scl_drive_low` is 1 for one tick interval and then 0 for one tick interval, and `sda_in` is sampled on the tick that ends the released interval.
- R4: The pulse train stops after the first pulse whose sample sees `sda_in` at 1. The number of pulses therefore equals the number of pulses the target needs before it lets go of SDA.
- R5: The sequencer issues at most MAX_PULSES pulses (8 by default). If SDA is still 0 after the last one, it raises `done` with `fail` 1, generates no STOP, and leaves both lines released.
- R6: When SDA has been released, or when R7 applies, the sequencer generates a STOP in three tick intervals. First SCL and SDA are both driven low. Then SCL is released while SDA stays low. Then SDA is released while SCL is high. `done` follows this sequence.
- R7: A request made while `sda_in` is 1 and `scl_in` is 0 produces no pulse train and goes straight to the STOP sequence of R6.
- R8: When a STOP sequence ends, `fail` is 1 if `sda_in` and `scl_in` are not both 1 at the closing tick, and 0 otherwise.
- R9: A recover request that arrives while a recovery is already running is ignored. It changes neither the pulse count nor the number of `done` strobes.
- R10: `done` is a single-cycle strobe, and `fail` is 1 only in a cycle where `done` is 1.
- R11: While a recovery is running, the drive outputs change only in the cycle after a `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recover_req | input | 1 | Single-cycle request to start a recovery |
| sda_in | input | 1 | Sampled SDA line level |
| scl_in | input | 1 | Sampled SCL line level |
| tick | input | 1 | Phase-advance enable from the timing generator |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| done | output | 1 | One-cycle completion strobe |
| fail | output | 1 | Recovery outcome, valid together with done |

## Verification
The embedded assertions check on every cycle that:
- the pulse counter never passes its limit;
- SDA is released only while SCL is already released, so a release is always a STOP edge and never a START edge;
- `done` never lasts two cycles;
- the line drives stay fixed between ticks;
- a failing end after the pulse limit is preceded by a low SDA sample.

The directed scenarios cover what only bus-level stimulus can show:
- the exact pulse count for targets that let go after 1, 3 or 8 pulses, and for a target that never lets go;
- the three routes chosen from the line levels at request time;
- the STOP seen on the wires;
- the outcome when SCL stays stuck low;
- a request made mid-recovery having no effect.

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam #(
  parameter int MAX_PULSES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_req,
  input  logic sda_in,
  input  logic scl_in,
  input  logic tick,
  output logic scl_drive_low,
  output logic sda_drive_low,
  output logic done,
  output logic fail
);

  localparam int CW = $clog2(MAX_PULSES + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_PULSES - 1);
  localparam logic [CW-1:0] CAP  = CW'(MAX_PULSES);

  typedef enum logic [2:0] {
    S_IDLE, S_PLO, S_PHI, S_SLO, S_SHI, S_SREL, S_FIN
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      fail_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (recover_req) begin
          cnt    <= '0;
          fail_q <= 1'b0;
          if (sda_in && scl_in) st <= S_FIN;
          else if (sda_in)      st <= S_SLO;
          else                  st <= S_PLO;
        end
        S_PLO: if (tick) st <= S_PHI;
        S_PHI: if (tick) begin
          cnt <= cnt + 1'b1;
          if (sda_in) st <= S_SLO;
          else if (cnt == LAST) begin
            fail_q <= 1'b1;
            st     <= S_FIN;
          end else st <= S_PLO;
        end
        S_SLO: if (tick) st <= S_SHI;
        S_SHI: if (tick) st <= S_SREL;
        S_SREL: if (tick) begin
          fail_q <= !(sda_in && scl_in);
          st     <= S_FIN;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign scl_drive_low = (st == S_PLO) || (st == S_SLO);
  assign sda_drive_low = (st == S_SLO) || (st == S_SHI);
  assign done          = (st == S_FIN);
  assign fail          = done && fail_q;

  wire running = (st != S_IDLE) && (st != S_FIN);

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP); // R5

  AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_low) |-> !scl_drive_low && !$past(scl_drive_low)); // R6

  AST_DONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick) |=> $stable(scl_drive_low) && $stable(sda_drive_low)); // R11

  AST_CAP_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fail) && cnt == CAP) |-> $past(!sda_in)); // R5

endmodule

// File: tb/tb_i2c_bus_unjam.sv
module tb_i2c_bus_unjam;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recover_req = 1'b0;
  logic tick_en = 1'b1;
  logic tick;
  logic scl_stuck = 1'b0;
  logic hold_active = 1'b0;
  int   hold_k = 0;
  logic sda_in, scl_in;
  logic scl_drive_low, sda_drive_low, done, fail;

  int checks = 0, errors = 0;
  int pulses = 0, releases = 0, done_cnt = 0;
  logic stop_seen = 1'b0, fail_at_done = 1'b0;
  logic p_scl_drv = 1'b0, p_sda_in = 1'b1, p_scl_in = 1'b1;
  int div = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) div <= (div == TICK_DIV-1) ? 0 : div + 1;
  assign tick   = tick_en && (div == TICK_DIV-1);
  assign sda_in = !sda_drive_low && !(hold_active && releases < hold_k);
  assign scl_in = !scl_drive_low && !scl_stuck;

  i2c_bus_unjam dut (
    .clk(clk), .rst_n(rst_n), .recover_req(recover_req),
    .sda_in(sda_in), .scl_in(scl_in), .tick(tick),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .done(done), .fail(fail)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (scl_drive_low && !p_scl_drv && !sda_drive_low) pulses++;
    if (!scl_drive_low && p_scl_drv) releases++;
    if (sda_in && !p_sda_in && scl_in && p_scl_in) stop_seen = 1'b1;
    if (done) begin
      done_cnt++;
      fail_at_done = fail;
    end
    if (fail && !done) chk("R10 fail without done", 1, 0);
    p_scl_drv = scl_drive_low;
    p_sda_in  = sda_in;
    p_scl_in  = scl_in;
  end

  task automatic clear_mon();
    pulses = 0; releases = 0; stop_seen = 1'b0; fail_at_done = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk) recover_req = 1'b1;
    @(negedge clk) recover_req = 1'b0;
  endtask

  task automatic wait_done(input int base);
    for (int i = 0; i < 3000 && done_cnt == base; i++) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic test_reset();
    chk("R1 scl drive", int'(scl_drive_low), 0);
    chk("R1 sda drive", int'(sda_drive_low), 0);
    chk("R1 done/fail", int'(done | fail), 0);
  endtask

  task automatic test_idle_bus();
    int base;
    clear_mon(); base = done_cnt;
    @(negedge clk) recover_req = 1'b1;
    @(negedge clk) recover_req = 1'b0;
    chk("R2 done next cycle", int'(done), 1);
    chk("R2 fail", int'(fail), 0);
    @(negedge clk);
    chk("R10 done single cycle", int'(done), 0);
    repeat (8) @(negedge clk);
    chk("R2 no pulses", pulses, 0);
    chk("R2 one done", done_cnt - base, 1);
  endtask

  task automatic test_release_after(input int k, input logic probe);
    int base;
    clear_mon(); base = done_cnt;
    hold_k = k; hold_active = 1'b1;
    pulse_req();
    if (probe) begin
      repeat (9) @(negedge clk);
      pulse_req();
      chk("R3 scl pulled mid-train or released", int'(sda_drive_low), 0);
    end
    wait_done(base);
    chk($sformatf("R4 pulses for k=%0d", k), pulses, k);
    chk("R6 stop seen on bus", int'(stop_seen), 1);
    chk("R8 fail clear after good stop", int'(fail_at_done), 0);
    if (probe) chk("R9 single done despite extra request", done_cnt - base, 1);
    hold_active = 1'b0;
  endtask

  task automatic test_never_release();
    int base;
    clear_mon(); base = done_cnt;
    hold_k = 1000; hold_active = 1'b1;
    pulse_req();
    wait_done(base);
    chk("R5 pulse cap", pulses, 8);
    chk("R5 fail at cap", int'(fail_at_done), 1);
    chk("R5 no stop", int'(stop_seen), 0);
    chk("R5 lines released", int'(scl_drive_low | sda_drive_low), 0);
    hold_active = 1'b0;
  endtask

  task automatic test_scl_stuck(input logic permanent);
    int base;
    clear_mon(); base = done_cnt;
    scl_stuck = 1'b1;
    pulse_req();
    if (!permanent) begin
      repeat (2) @(negedge clk);
      scl_stuck = 1'b0;
    end
    wait_done(base);
    chk("R7 no pulses", pulses, 0);
    if (permanent) begin
      chk("R8 fail when scl stays low", int'(fail_at_done), 1);
    end else begin
      chk("R7 stop seen", int'(stop_seen), 1);
      chk("R8 no fail", int'(fail_at_done), 0);
    end
    scl_stuck = 1'b0;
  endtask

  task automatic test_no_tick();
    int base;
    logic moved;
    clear_mon(); base = done_cnt;
    hold_k = 2; hold_active = 1'b1;
    @(negedge clk) tick_en = 1'b0;
    pulse_req();
    moved = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!scl_drive_low) moved = 1'b1;
    end
    chk("R11 holds without tick", int'(moved), 0);
    tick_en = 1'b1;
    wait_done(base);
    chk("R3 pulses after tick resumes", pulses, 2);
    hold_active = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_idle_bus();
    test_release_after(1, 1'b0);
    test_release_after(3, 1'b1);
    test_release_after(8, 1'b0);
    test_never_release();
    test_scl_stuck(1'b0);
    test_scl_stuck(1'b1);
    test_no_tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule